// File: doc/BRIEF.md
# Delta-Modulation Tracking Controller

This block is the digital heart of a tracking delta-modulation converter. Two comparator flags arrive from outside. One says the analog input now lies above the upper reference. The other says it lies below the lower reference. The controller holds a running level and adjusts it by one step in the direction the flags ask. It also drives a one-hot select that chooses which pair of adjacent references, one LSB apart, the external resistor ladder presents to the comparators.

Each accepted step leaves the block as a token: a one-cycle valid strobe plus a direction bit. Downstream logic can rebuild the signal from the timing and direction of these tokens.

After each step a lockout counter holds off further decisions for a set number of cycles. During that time the ladder and comparators settle, so a stale flag cannot produce a spurious step. Steps past either end of the range are refused, and each end has an enable output that shows whether a step that way is allowed. A synchronous reset returns the level to mid-scale.

Top module: `dm_track_ctrl`

## Requirements
- R1: When `cmp_above_i` is high, `cmp_below_i` is low, the lockout is idle and the level is below its maximum, the level rises by exactly one at the next clock edge.
- R2: When `cmp_below_i` is high, `cmp_above_i` is low, the lockout is idle and the level is above zero, the level falls by exactly one at the next clock edge.
- R3: `ref_sel_o` is one-hot at all times, and bit number N is set when `level_o` equals N.
- R4: Each accepted step makes `tok_valid_o` high for exactly the one cycle after the edge that moves the level. In that cycle `tok_up_o` is 1 for a rise and 0 for a fall. When `tok_valid_o` is low, `tok_up_o` is 0.
- R5: After an accepted step, the flags are ignored for the next LOCK_CYC cycles (3 by default). The earliest next acceptance is LOCK_CYC+1 cycles after the previous one.
- R6: At the maximum level (63), `rise_en_o` is 0. A rise request then changes nothing, issues no token and does not start the lockout.
- R7: At level 0, `fall_en_o` is 0. A fall request then changes nothing, issues no token and does not start the lockout.
- R8: When both flags are high in the same cycle, neither is acted on. No token is issued and the lockout is not started.
- R9: A synchronous reset sets the level to 32, clears the token outputs and clears the lockout, so a request in the first cycle after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_above_i | input | 1 | Input is above the upper reference |
| cmp_below_i | input | 1 | Input is below the lower reference |
| level_o | output | LEVEL_W (6) | Running level |
| ref_sel_o | output | 2**LEVEL_W (64) | One-hot reference-pair select |
| tok_valid_o | output | 1 | One-cycle token strobe |
| tok_up_o | output | 1 | Token direction, 1 = rise |
| rise_en_o | output | 1 | A rise step is permitted |
| fall_en_o | output | 1 | A fall step is permitted |

## Verification
The bench keeps a cycle-accurate model of the level and the lockout, and pushes the design through long single-direction runs into both rails. At the rails, a design that wraps would jump from 63 to 0 and emit a bogus token, and a design that lets a blocked request start the lockout would delay the next legal step. Stretches with both flags high, and a pseudo-random flag stream that hits every level, catch an arbiter that favours one flag or a lockout that is one cycle too short or too long, since either shifts the token times. A reset asserted in the middle of a lockout checks that the counter is really cleared, so the first request after reset is taken at once.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
   typedef enum logic [1:0] {
      STEP_NONE = 2'd0,
      STEP_RISE = 2'd1,
      STEP_FALL = 2'd2
   } step_e;

   function automatic logic step_moves(input step_e s);
      return s != STEP_NONE;
   endfunction
endpackage

// File: rtl/dmt_lockout.sv
module dmt_lockout #(
   parameter int LOCK_CYC = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = (LOCK_CYC < 1) ? 1 : $clog2(LOCK_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYC);

   initial begin
      if (LOCK_CYC < 1) $error("LOCK_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (start_i)
         cnt_q <= LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   assert_start_idle_R5: assert property (@(posedge clk) disable iff (rst)
      start_i |-> !busy_o);
   assert_lock_arm_R5: assert property (@(posedge clk) disable iff (rst)
      start_i |=> busy_o);
endmodule

// File: rtl/dmt_arbiter.sv
module dmt_arbiter
   import dmt_pkg::*;
(
   input  logic  rise_req_i,
   input  logic  fall_req_i,
   input  logic  busy_i,
   input  logic  rise_ok_i,
   input  logic  fall_ok_i,
   output step_e step_o
);
   logic only_rise, only_fall;

   always_comb begin
      only_rise = rise_req_i & ~fall_req_i;
      only_fall = fall_req_i & ~rise_req_i;
      step_o    = STEP_NONE;
      if (!busy_i) begin
         if (only_rise && rise_ok_i)
            step_o = STEP_RISE;
         else if (only_fall && fall_ok_i)
            step_o = STEP_FALL;
      end
   end
endmodule

// File: rtl/dmt_level.sv
module dmt_level
   import dmt_pkg::*;
#(
   parameter int LEVEL_W     = 6,
   parameter int RESET_LEVEL = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  step_e              step_i,
   output logic [LEVEL_W-1:0] level_o,
   output logic               rise_ok_o,
   output logic               fall_ok_o
);
   localparam logic [LEVEL_W-1:0] LVL_MAX  = '1;
   localparam logic [LEVEL_W-1:0] LVL_INIT = LEVEL_W'(RESET_LEVEL);

   initial begin
      if (RESET_LEVEL < 0 || RESET_LEVEL >= (1 << LEVEL_W))
         $error("RESET_LEVEL out of range");
   end

   logic [LEVEL_W-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (rst)
         lvl_q <= LVL_INIT;
      else if (step_i == STEP_RISE)
         lvl_q <= lvl_q + 1'b1;
      else if (step_i == STEP_FALL)
         lvl_q <= lvl_q - 1'b1;
   end

   assign level_o   = lvl_q;
   assign rise_ok_o = (lvl_q != LVL_MAX);
   assign fall_ok_o = (lvl_q != '0);

   assert_rise_step_R1: assert property (@(posedge clk) disable iff (rst)
      step_i == STEP_RISE |=> lvl_q == $past(lvl_q) + 1'b1);
   assert_fall_step_R2: assert property (@(posedge clk) disable iff (rst)
      step_i == STEP_FALL |=> lvl_q == $past(lvl_q) - 1'b1);
   assert_no_wrap_top_R6: assert property (@(posedge clk) disable iff (rst)
      lvl_q == LVL_MAX |=> lvl_q != '0);
   assert_no_wrap_bot_R7: assert property (@(posedge clk) disable iff (rst)
      lvl_q == '0 |=> lvl_q != LVL_MAX);
endmodule

// File: rtl/dmt_onehot_dec.sv
module dmt_onehot_dec #(
   parameter int IN_W  = 6,
   parameter int STYLE = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [IN_W-1:0]      code_i,
   output logic [(1<<IN_W)-1:0] sel_o
);
   localparam int LINES = 1 << IN_W;

   initial begin
      if (STYLE != 0 && STYLE != 1) $error("STYLE must be 0 or 1");
   end

   generate
      if (STYLE == 0) begin : g_shift
         assign sel_o = LINES'(1) << code_i;
      end else begin : g_compare
         for (genvar i = 0; i < LINES; i++) begin : g_line
            assign sel_o[i] = (code_i == IN_W'(i));
         end
      end
   endgenerate

   assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $countones(sel_o) == 1);
endmodule

// File: rtl/dm_track_ctrl.sv
module dm_track_ctrl
   import dmt_pkg::*;
#(
   parameter int LEVEL_W     = 6,
   parameter int LOCK_CYC    = 3,
   parameter int RESET_LEVEL = 1 << (LEVEL_W - 1),
   parameter int DEC_STYLE   = 0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cmp_above_i,
   input  logic                    cmp_below_i,
   output logic [LEVEL_W-1:0]      level_o,
   output logic [(1<<LEVEL_W)-1:0] ref_sel_o,
   output logic                    tok_valid_o,
   output logic                    tok_up_o,
   output logic                    rise_en_o,
   output logic                    fall_en_o
);
   localparam logic [LEVEL_W-1:0] LVL_MAX  = '1;
   localparam logic [LEVEL_W-1:0] LVL_INIT = LEVEL_W'(RESET_LEVEL);

   initial begin
      if (LEVEL_W < 2 || LEVEL_W > 10) $error("LEVEL_W must be 2..10");
   end

   step_e step;
   logic  busy, rise_ok, fall_ok;
   logic  tv_q, tu_q;

   dmt_arbiter u_arb (
      .rise_req_i (cmp_above_i),
      .fall_req_i (cmp_below_i),
      .busy_i     (busy),
      .rise_ok_i  (rise_ok),
      .fall_ok_i  (fall_ok),
      .step_o     (step)
   );

   dmt_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk     (clk),
      .rst     (rst),
      .start_i (step_moves(step)),
      .busy_o  (busy)
   );

   dmt_level #(.LEVEL_W(LEVEL_W), .RESET_LEVEL(RESET_LEVEL)) u_lvl (
      .clk       (clk),
      .rst       (rst),
      .step_i    (step),
      .level_o   (level_o),
      .rise_ok_o (rise_ok),
      .fall_ok_o (fall_ok)
   );

   dmt_onehot_dec #(.IN_W(LEVEL_W), .STYLE(DEC_STYLE)) u_dec (
      .clk    (clk),
      .rst    (rst),
      .code_i (level_o),
      .sel_o  (ref_sel_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         tv_q <= 1'b0;
         tu_q <= 1'b0;
      end else begin
         tv_q <= step_moves(step);
         tu_q <= (step == STEP_RISE);
      end
   end

   assign tok_valid_o = tv_q;
   assign tok_up_o    = tu_q;
   assign rise_en_o   = rise_ok;
   assign fall_en_o   = fall_ok;

   assert_tok_dir_R4: assert property (@(posedge clk) disable iff (rst)
      tok_valid_o |-> (tok_up_o ? (level_o == $past(level_o) + 1'b1)
                                : (level_o == $past(level_o) - 1'b1)));
   assert_tok_idle_R4: assert property (@(posedge clk) disable iff (rst)
      !tok_valid_o |-> !tok_up_o);
   assert_tok_gap_R5: assert property (@(posedge clk) disable iff (rst)
      tok_valid_o |=> !tok_valid_o);
   assert_top_block_R6: assert property (@(posedge clk) disable iff (rst)
      level_o == LVL_MAX |=> !(tok_valid_o && tok_up_o));
   assert_bot_block_R7: assert property (@(posedge clk) disable iff (rst)
      level_o == '0 |=> !(tok_valid_o && !tok_up_o));
   assert_both_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (cmp_above_i && cmp_below_i) |=> !tok_valid_o);
   assert_reset_mid_R9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (level_o == LVL_INIT && !tok_valid_o));
endmodule

// File: tb/dm_track_ctrl_tb_top.sv
`timescale 1ns/1ps
module dm_track_ctrl_tb_top;
   localparam int LW   = 6;
   localparam int LK   = 3;
   localparam int LMAX = (1 << LW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic above = 1'b0, below = 1'b0;
   logic [LW-1:0]      level;
   logic [(1<<LW)-1:0] sel;
   logic tv, tu, ren, fen;

   int tests = 0, fails = 0;
   bit done = 0;
   int m_lvl = 32, m_lock = 0, m_tv = 0, m_tu = 0;

   always #2 clk = ~clk;

   dm_track_ctrl #(.LEVEL_W(LW), .LOCK_CYC(LK)) dut_i (
      .clk(clk), .rst(rst), .cmp_above_i(above), .cmp_below_i(below),
      .level_o(level), .ref_sel_o(sel), .tok_valid_o(tv), .tok_up_o(tu),
      .rise_en_o(ren), .fall_en_o(fen)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit a, input bit b, input bit r);
      string tag;
      bit up, dn;
      above = a; below = b; rst = r;
      up = a && !b && m_lock == 0 && m_lvl != LMAX;
      dn = b && !a && m_lock == 0 && m_lvl != 0;
      if (r)                       tag = "R9";
      else if (a && b)             tag = "R8";
      else if (m_lock != 0 && (a || b)) tag = "R5";
      else if (a && m_lvl == LMAX) tag = "R6";
      else if (b && m_lvl == 0)    tag = "R7";
      else if (dn)                 tag = "R2";
      else                         tag = "R1";
      @(posedge clk);
      if (r) begin
         m_lvl = 32; m_lock = 0; m_tv = 0; m_tu = 0;
      end else begin
         m_tv = (up || dn) ? 1 : 0;
         m_tu = up ? 1 : 0;
         if (up) begin m_lvl++; m_lock = LK; end
         else if (dn) begin m_lvl--; m_lock = LK; end
         else if (m_lock > 0) m_lock--;
      end
      @(negedge clk);
      chk(tag, int'(level), m_lvl);
      chk("R3", int'(sel == ((1<<LW)'(1) << m_lvl)), 1);
      chk("R4 valid", int'(tv), m_tv);
      chk("R4 up", int'(tu), m_tu);
      chk("R6 rise_en", int'(ren), int'(m_lvl != LMAX));
      chk("R7 fall_en", int'(fen), int'(m_lvl != 0));
   endtask

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      int vin;
      @(negedge clk);
      cyc(0, 0, 1);
      cyc(0, 0, 1);
      // R9: reset state
      chk("R9 level", int'(level), 32);
      chk("R9 tok", int'(tv), 0);
      // R1, R5, R6: run into the top rail
      for (int i = 0; i < 160; i++) cyc(1, 0, 0);
      chk("R6 at top", int'(level), LMAX);
      // R2, R7: run into the bottom rail
      for (int i = 0; i < 300; i++) cyc(0, 1, 0);
      chk("R7 at bottom", int'(level), 0);
      // blocked fall must not start lockout: next rise accepted at once (R7)
      cyc(1, 0, 0);
      chk("R7 no lockout", int'(tv), 1);
      // R8: both flags
      for (int i = 0; i < 6; i++) cyc(0, 0, 0);
      for (int i = 0; i < 12; i++) cyc(1, 1, 0);
      cyc(0, 1, 0);
      chk("R8 no lockout", int'(tv), 1);
      // R9: reset in the middle of a lockout
      for (int i = 0; i < 6; i++) cyc(0, 0, 0);
      cyc(1, 0, 0);
      cyc(0, 0, 1);
      cyc(1, 0, 0);
      chk("R9 lock cleared", int'(tv), 1);
      // tracking loop against a ramp input
      vin = 32;
      for (int i = 0; i < 1200; i++) begin
         if (i % 9 == 0) vin = (i < 600) ? ((vin < LMAX) ? vin + 1 : vin)
                                         : ((vin > 0) ? vin - 1 : vin);
         cyc(vin > m_lvl, vin < m_lvl, 0);
      end
      // pseudo-random flag sweep covering all flag combinations at every level
      for (int i = 0; i < 6000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0], lfsr[3] & ~(lfsr[5] & (m_lvl < 8)), lfsr[15:6] == 10'h3FF);
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule